// File: doc/BRIEF.md
# Two-Wire Block-Mode Configuration Register Slave

This block is a serial slave for a two-wire bus made of a clock line and an open-drain data line. It keeps three 8-bit configuration registers, each with a fixed value after reset. The first two registers drive downstream logic through a parallel output. The third can only be written and read over the bus. Both bus lines pass through synchronisers clocked by a system clock that runs at least eight times the bus rate. The slave detects start, stop and repeated-start conditions, matches its address, and answers each byte with an acknowledge (the line pulled low) or a not-acknowledge (the line left released).

Every access uses block mode. A write sends the device address with the write bit, then the command code 0x00, then a byte count, and then data bytes that fill the registers from index 0 upward. A read first sends the address and the 0x00 command as a write. The master then issues a repeated start and the address with the read bit. The slave replies with the byte count, which is always 3, and then the registers in index order. The master acknowledges each byte it wants to continue with and answers the last byte with a not-acknowledge.

There is no streaming interface, so there is no valid/ready handshake and no back-pressure. The register output is a plain level that changes only when a data byte is committed. The data line is driven as a pull-low enable, and the surrounding pad makes it open-drain.

Top module: `twcfg_slave`

## Requirements
- R1: After reset, register 0 holds 0xFF, register 1 holds 0xC0 and register 2 holds 0xFF. `cfg_o` equals 16'hC0FF and the data line is released.
- R2: The address byte 0xD2 (device address 0x69 in bits 7:1, write bit 0 in bit 0) is acknowledged. Any other address byte gets a not-acknowledge, and the rest of that transaction changes no register and gets no acknowledge.
- R3: After an acknowledged write address, the command byte 0x00 is acknowledged. Any other command gets a not-acknowledge, and the bytes that follow it change no register.
- R4: In a block write, the byte after the command is a byte count and is acknowledged. Each following data byte is acknowledged and is stored, most significant bit first, into registers 0, 1 and 2 in that order. Data bytes after the third are acknowledged and discarded.
- R5: Bits 5:0 of register 1 ignore writes and always read back as zero. Bits 7:6 of register 1 take the written value.
- R6: A stop after any complete data byte ends the transfer, and every byte already received stays stored.
- R7: After the address with write bit and the 0x00 command, a repeated start and the address byte 0xD3 (read bit 1 in bit 0) are acknowledged. The slave then sends the count 3 and registers 0, 1, 2, each most significant bit first. After a not-acknowledge from the master, the slave leaves the line released; any further byte reads as 0xFF.
- R8: A read address that is not preceded, in the same transaction, by an accepted 0x00 command gets a not-acknowledge.
- R9: A start or stop detected after at least one complete bit of a byte aborts the transaction and changes no register. After such a start, the slave ignores everything until the next start.
- R10: The slave changes the data line only while the clock line is low, and it releases the line after every stop.
- R11: `cfg_o[7:0]` is register 0 and `cfg_o[15:8]` is register 1. A data byte becomes visible there two system clocks after the synchronised clock fall that follows its eighth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen at the pad (asynchronous) |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |
| cfg_o | output | 16 | Registers 0 and 1: register 0 in bits 7:0, register 1 in bits 15:8 |

## Verification
Two events can fall on the same synchronised clock fall:
- storing a received data byte into a register;
- driving the acknowledge for that byte.

A read also shares one fall between two actions: releasing the acknowledge and driving the first bit of the next transmitted byte.

The bench provokes both overlaps by sweeping data values through full block writes and block reads. It also ends transfers after partial byte counts and aborts them mid-byte. Each case is judged by the acknowledge bits the master sees, by `cfg_o`, and by the register values read back through the bus.

// File: rtl/twcfg_pkg.sv
package twcfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_COUNT, ST_WDATA, ST_RCOUNT, ST_RDATA, ST_WAIT
  } stage_t;

  function automatic logic is_tx(input stage_t s);
    return (s == ST_RCOUNT) || (s == ST_RDATA);
  endfunction
endpackage

// File: rtl/twcfg_sync.sv
module twcfg_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta;
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        meta[g]   <= 1'b1;
        sync_o[g] <= 1'b1;
      end else begin
        meta[g]   <= async_i[g];
        sync_o[g] <= meta[g];
      end
    end
  end
endmodule

// File: rtl/twcfg_cond.sv
module twcfg_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  // R9: at most one bus event per cycle, so an abort never meets a bit edge
  assert_one_event_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({scl_rise, scl_fall, start_det, stop_det}));
endmodule

// File: rtl/twcfg_regbank.sv
module twcfg_regbank #(
  parameter int              NREG    = 3,
  parameter logic [8*NREG-1:0] RST_VAL = '1,
  parameter logic [8*NREG-1:0] WR_MASK = '1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [$clog2(NREG+1)-1:0]    widx,
  input  logic [7:0]                   wdata,
  output logic [8*NREG-1:0]            regs_o
);
  localparam int CW = $clog2(NREG + 1);

  logic [7:0] r [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] RV = RST_VAL[8*g +: 8];
    localparam logic [7:0] WM = WR_MASK[8*g +: 8];
    always_ff @(posedge clk) begin
      if (rst)
        r[g] <= RV;
      else if (we && widx == CW'(g))
        r[g] <= (wdata & WM) | (RV & ~WM);
    end
    assign regs_o[8*g +: 8] = r[g];
  end

  // R6: stored bytes only move on a commit strobe
  assert_hold_without_write_R6: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(regs_o));
endmodule

// File: rtl/twcfg_engine.sv
module twcfg_engine
  import twcfg_pkg::*;
#(
  parameter int         NREG      = 3,
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter logic [7:0] BLOCK_CMD = 8'h00
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      scl_rise,
  input  logic                      scl_fall,
  input  logic                      start_det,
  input  logic                      stop_det,
  input  logic                      sda_s,
  input  logic [8*NREG-1:0]         rd_regs,
  output logic                      we_o,
  output logic [$clog2(NREG+1)-1:0] widx_o,
  output logic [7:0]                wdata_o,
  output logic                      sda_pull_o
);
  localparam int CW = $clog2(NREG + 1);
  localparam logic [CW-1:0] PTR_END = CW'(NREG);

  stage_t        stage, nxt;
  logic [3:0]    bitcnt;
  logic          bitfell, armed, mack;
  logic [7:0]    sreg, txsr, ld_byte;
  logic [CW-1:0] ptr;

  always_comb begin
    ld_byte = 8'hFF;
    if (nxt == ST_RCOUNT) ld_byte = 8'(NREG);
    else
      for (int i = 0; i < NREG; i++)
        if (ptr == CW'(i)) ld_byte = rd_regs[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    we_o <= 1'b0;
    if (rst) begin
      stage <= ST_IDLE;  nxt <= ST_IDLE;  bitcnt <= '0;  bitfell <= 1'b0;
      armed <= 1'b0;  mack <= 1'b0;  sreg <= '0;  txsr <= '0;  ptr <= '0;
      widx_o <= '0;  wdata_o <= '0;  sda_pull_o <= 1'b0;
    end else if (stop_det) begin
      stage <= ST_IDLE;  bitcnt <= '0;  bitfell <= 1'b0;  armed <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (start_det) begin
      bitcnt <= '0;  bitfell <= 1'b0;  sda_pull_o <= 1'b0;
      if (bitfell) begin
        stage <= ST_IDLE;
        armed <= 1'b0;
      end else begin
        stage <= ST_ADDR;
      end
    end else if (stage != ST_IDLE && stage != ST_WAIT) begin
      if (scl_rise) begin
        if (bitcnt == 4'd8) begin
          mack   <= ~sda_s;
          bitcnt <= 4'd9;
        end else if (bitcnt < 4'd8) begin
          sreg   <= {sreg[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end
      end else if (scl_fall) begin
        if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
          bitfell <= 1'b1;
          if (is_tx(stage)) begin
            sda_pull_o <= ~txsr[6];
            txsr       <= {txsr[6:0], 1'b0};
          end
        end else if (bitcnt == 4'd8) begin
          bitfell <= 1'b1;
          unique case (stage)
            ST_ADDR: begin
              if (sreg == {DEV_ADDR, 1'b0}) begin
                sda_pull_o <= 1'b1;  nxt <= ST_CMD;  armed <= 1'b0;
              end else if (sreg == {DEV_ADDR, 1'b1} && armed) begin
                sda_pull_o <= 1'b1;  nxt <= ST_RCOUNT;  ptr <= '0;
              end else begin
                nxt <= ST_WAIT;
              end
            end
            ST_CMD: begin
              if (sreg == BLOCK_CMD) begin
                sda_pull_o <= 1'b1;  nxt <= ST_COUNT;  armed <= 1'b1;  ptr <= '0;
              end else begin
                nxt <= ST_WAIT;
              end
            end
            ST_COUNT: begin
              sda_pull_o <= 1'b1;  nxt <= ST_WDATA;
            end
            ST_WDATA: begin
              sda_pull_o <= 1'b1;  nxt <= ST_WDATA;
              if (ptr != PTR_END) begin
                we_o    <= 1'b1;
                widx_o  <= ptr;
                wdata_o <= sreg;
                ptr     <= ptr + 1'b1;
              end
            end
            ST_RCOUNT, ST_RDATA: begin
              sda_pull_o <= 1'b0;  nxt <= ST_RDATA;
            end
            default: nxt <= ST_WAIT;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt     <= '0;
          bitfell    <= 1'b0;
          sda_pull_o <= 1'b0;
          if (is_tx(stage) && !mack) begin
            stage <= ST_WAIT;
          end else begin
            stage <= nxt;
            if (is_tx(nxt)) begin
              txsr       <= ld_byte;
              sda_pull_o <= ~ld_byte[7];
              if (nxt == ST_RDATA && ptr != PTR_END) ptr <= ptr + 1'b1;
            end
          end
        end
      end
    end
  end

  // R2: when receiving, the line is pulled only around the acknowledge slot
  assert_rx_pull_in_ack_slot_R2: assert property (@(posedge clk) disable iff (rst)
    (sda_pull_o && !is_tx(stage)) |-> (bitcnt >= 4'd8));
  // R10: a stop always leaves the line released
  assert_release_after_stop_R10: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_pull_o);
  // R4: a commit only happens while a block write is in progress
  assert_commit_in_write_R4: assert property (@(posedge clk) disable iff (rst)
    we_o |-> (stage == ST_WDATA));
endmodule

// File: rtl/twcfg_slave.sv
module twcfg_slave #(
  parameter int                NREG      = 3,
  parameter int                N_OUT     = 2,
  parameter logic [6:0]        DEV_ADDR  = 7'h69,
  parameter logic [7:0]        BLOCK_CMD = 8'h00,
  parameter logic [8*NREG-1:0] RST_VAL   = 24'hFF_C0_FF,
  parameter logic [8*NREG-1:0] WR_MASK   = 24'hFF_C0_FF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  output logic [8*N_OUT-1:0] cfg_o
);
  localparam int CW = $clog2(NREG + 1);

  logic              scl_s, sda_s;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              we;
  logic [CW-1:0]     widx;
  logic [7:0]        wdata;
  logic [8*NREG-1:0] regs;

  twcfg_sync #(.W(2)) u_sync (
    .clk(clk), .rst(rst), .async_i({scl_i, sda_i}), .sync_o({scl_s, sda_s})
  );

  twcfg_cond u_cond (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twcfg_engine #(.NREG(NREG), .DEV_ADDR(DEV_ADDR), .BLOCK_CMD(BLOCK_CMD)) u_engine (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .rd_regs(regs), .we_o(we), .widx_o(widx), .wdata_o(wdata),
    .sda_pull_o(sda_pull_o)
  );

  twcfg_regbank #(.NREG(NREG), .RST_VAL(RST_VAL), .WR_MASK(WR_MASK)) u_regs (
    .clk(clk), .rst(rst), .we(we), .widx(widx), .wdata(wdata), .regs_o(regs)
  );

  assign cfg_o = regs[8*N_OUT-1:0];

  // R10: the data line moves only while the synchronised clock is low
  assert_sda_low_phase_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull_o) |-> !scl_s);
  // R11: the output changes two cycles after a detected clock fall
  assert_commit_on_fall_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_o) |-> $past(scl_fall, 2));
endmodule

// File: tb/tb_twcfg_slave.sv
module tb_twcfg_slave;
  localparam int Q = 4;

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, m_low = 1'b0;
  logic sda_pull;
  logic [15:0] cfg;
  wire sda_line = ~(m_low | sda_pull);
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  twcfg_slave dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .cfg_o(cfg)
  );

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    m_low = 1'b0; wq; scl = 1'b1; wq; m_low = 1'b1; wq; scl = 1'b0; wq;
  endtask

  task automatic bus_stop;
    m_low = 1'b1; wq; scl = 1'b1; wq; m_low = 1'b0; wq;
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_low = ~b; wq; scl = 1'b1; wq; s = sda_line; wq; scl = 1'b0; wq;
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      v[i] = s;
    end
    clk_bit(~give_ack, s);
  endtask

  task automatic send_bits(input logic [7:0] v, input int nb);
    logic s;
    for (int i = 0; i < nb; i++) clk_bit(v[7-i], s);
  endtask

  task automatic write_seq(input logic [7:0] a, input logic [63:0] d, input int n,
                           output logic [8:0] ak);
    logic x;
    ak = '0;
    bus_start;
    wr_byte(a, x); ak[0] = x;
    for (int k = 0; k < n; k++) begin
      wr_byte(d[8*k +: 8], x);
      ak[k+1] = x;
    end
    bus_stop;
  endtask

  task automatic rd_all(output logic [31:0] got, output logic [2:0] ak);
    logic x;
    logic [7:0] c, r0, r1, r2;
    bus_start;
    wr_byte(8'hD2, x); ak[0] = x;
    wr_byte(8'h00, x); ak[1] = x;
    bus_start;
    wr_byte(8'hD3, x); ak[2] = x;
    rd_byte(1'b1, c); rd_byte(1'b1, r0); rd_byte(1'b1, r1); rd_byte(1'b0, r2);
    bus_stop;
    got = {c, r2, r1, r0};
  endtask

  task automatic expect_regs(input string tag, input logic [7:0] e0, e1, e2);
    logic [31:0] got;
    logic [2:0] ak;
    rd_all(got, ak);
    chk({tag, " read acks"}, {29'd0, ak}, 32'h7);
    chk({tag, " readback"}, got, {8'd3, e2, e1, e0});
    chk({tag, " cfg_o"}, {16'd0, cfg}, {16'd0, e1, e0});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [8:0] ak;
    logic [7:0] b0, b1;
    logic x;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1: reset state
    chk("R1 cfg_o after reset", {16'd0, cfg}, 32'h0000C0FF);
    chk("R1 line released", {31'd0, sda_pull}, 32'd0);
    expect_regs("R1", 8'hFF, 8'hC0, 8'hFF);

    // R2 / R8: sweep every address byte with nothing armed
    for (int a = 0; a < 256; a++) begin
      write_seq(8'(a), 64'd0, 0, ak);
      chk(a == 8'hD3 ? "R8 unarmed read addr ack" : "R2 address ack",
          {31'd0, ak[0]}, {31'd0, (a == 8'hD2)});
    end

    // R2: foreign address, following bytes must be ignored
    write_seq(8'hD4, {24'd0, 8'h33, 8'h22, 8'h11, 8'h03, 8'h00}, 5, ak);
    chk("R2 foreign address acks", {23'd0, ak}, 32'd0);
    expect_regs("R2 foreign no effect", 8'hFF, 8'hC0, 8'hFF);

    // R3: non-block command
    write_seq(8'hD2, {32'd0, 8'h5A, 8'h03, 8'h05}, 3, ak);
    chk("R3 bad command acks", {23'd0, ak}, 32'h1);
    expect_regs("R3 bad command no effect", 8'hFF, 8'hC0, 8'hFF);

    // R4 / R5 / R11 / R7: sweep of full block writes with readback
    for (int k = 0; k < 32; k++) begin
      logic [7:0] v0, v1, v2;
      v0 = 8'(k * 8 + 3);
      v1 = ~v0;
      v2 = v0 ^ 8'hA5;
      write_seq(8'hD2, {16'd0, v2, v1, v0, 8'h03, 8'h00}, 5, ak);
      chk("R4 block write acks", {23'd0, ak}, 32'h3F);
      expect_regs("R4 R5 R7 R11 sweep", v0, v1 & 8'hC0, v2);
    end

    // R4: surplus bytes acknowledged and dropped
    write_seq(8'hD2, {8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'h05, 8'h00}, 7, ak);
    chk("R4 surplus acks", {23'd0, ak}, 32'hFF);
    expect_regs("R4 surplus dropped", 8'h11, 8'h00, 8'h33);

    // R6: stop after the first data byte
    write_seq(8'hD2, {40'd0, 8'h77, 8'h03, 8'h00}, 3, ak);
    chk("R6 partial acks", {23'd0, ak}, 32'hF);
    expect_regs("R6 partial kept", 8'h77, 8'h00, 8'h33);

    // R9: stop in the middle of a data byte
    bus_start;
    wr_byte(8'hD2, x); wr_byte(8'h00, x); wr_byte(8'h03, x);
    send_bits(8'h00, 4);
    bus_stop;
    expect_regs("R9 mid-byte stop", 8'h77, 8'h00, 8'h33);

    // R9: start in the middle of a data byte leaves the slave idle
    bus_start;
    wr_byte(8'hD2, x); wr_byte(8'h00, x); wr_byte(8'h03, x);
    send_bits(8'h00, 3);
    bus_start;
    wr_byte(8'hD2, x);
    chk("R9 address after mid-byte start", {31'd0, x}, 32'd0);
    wr_byte(8'h00, x);
    bus_stop;
    expect_regs("R9 mid-byte start", 8'h77, 8'h00, 8'h33);

    // R7: master ends the read after the count; the line stays released
    bus_start;
    wr_byte(8'hD2, x); wr_byte(8'h00, x);
    bus_start;
    wr_byte(8'hD3, x);
    chk("R7 read address ack", {31'd0, x}, 32'd1);
    rd_byte(1'b0, b0);
    chk("R7 count byte", {24'd0, b0}, 32'd3);
    rd_byte(1'b0, b1);
    chk("R7 released after nack", {24'd0, b1}, 32'hFF);
    bus_stop;
    chk("R10 released after stop", {31'd0, sda_pull}, 32'd0);

    // R8: read address directly after a start
    write_seq(8'hD3, 64'd0, 0, ak);
    chk("R8 direct read nack", {23'd0, ak}, 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule